// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames from a byte stream into memory buffers. Software lays out a circular table of 8-byte buffer descriptors in memory. It programs the table's base address, then hands buffers to the engine by moving a byte-offset limit pointer. The engine fetches one descriptor at a time. It copies each frame byte by byte into the buffer that descriptor names, then steps to the next entry. A flag inside a descriptor sends the following fetch back to the start of the table. The descriptors are never written back.

Software learns of new frames through a one-cycle completion pulse and a status position. The status position is a byte offset, in the same units as the limit. It advances one descriptor per finished frame. When the engine's position reaches the limit it holds there. A frame that starts during that hold is discarded, and a sticky overflow flag records the loss. Because the limit must always point one entry past the last usable buffer, at most one entry fewer than the table holds can be outstanding. A full ring therefore never looks the same as an empty one.

Top module: `rxring_dma`

## Requirements
- R1: After reset, the base, limit and status registers read zero, the overflow flag is clear, no memory access is made and `irq_done` and `frame_err` are low.
- R2: For the descriptor at position P, the engine reads the control word at base+P and then the buffer address word at base+P+4. The control word carries the buffer length in bits 12:0 and the end-of-table flag in bit 28.
- R3: The bytes of a frame are written one per memory write, in arrival order, to consecutive byte addresses starting at the descriptor's buffer address.
- R4: The cycle after the last byte of a frame (the byte with `in_eof` set) is accepted, `irq_done` is high for exactly one cycle. In that same cycle the status position has advanced by 8.
- R5: When the finished descriptor carried the end-of-table flag, the status position becomes 0 instead, and the next descriptor is fetched at the base address.
- R6: The engine fetches and fills only while its position differs from the limit. At equality it makes no memory access until software writes a different limit. Limit bits 2:0 are ignored and read back as zero.
- R7: A frame whose first byte (`in_sof` set) arrives while the engine is held at the limit is accepted and dropped entirely. It causes no memory write and no `irq_done`, and it sets the overflow flag (status bit 31).
- R8: Writing the status register with bit 31 set clears the overflow flag, and writing it with bit 31 clear leaves the flag as it is. A drop in the same cycle as a clearing write leaves the flag set.
- R9: Bytes beyond the descriptor's buffer length are not written. `frame_err` is high together with `irq_done` for a frame longer than its buffer, and low otherwise. A frame that exactly fills its buffer is not an error.
- R10: Register address 0 is the ring base (bits 2:0 read as zero), address 1 is the limit, and address 2 is the status. Status holds the position in bits 11:0 and the overflow flag in bit 31. Reads are combinational.
- R11: Bytes that arrive without `in_sof` while the engine waits for a frame start are discarded without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read word, valid the cycle after the read request |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Engine accepts the stream byte this cycle |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| irq_done | output | 1 | One-cycle frame completion pulse |
| frame_err | output | 1 | Frame was truncated; valid with `irq_done` |

## Verification
A drop that sets the overflow flag and a software write that clears it can land in the same cycle. The bench provokes this by holding the engine at its limit, then presenting a single-byte frame start and a status write with bit 31 set on the same clock edge. The case is judged by reading status afterwards and expecting the flag still set, followed by an ordinary clearing write that does take effect. A scoreboard also matches every memory write and every completion pulse against queued predictions. Any write or pulse during the stalled or dropped stretches is therefore reported as unexpected.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   typedef enum logic [2:0] {
      S_IDLE,    // waiting for room below the limit, or held at it
      S_FCTL,    // read request for the control word
      S_FADR,    // capture control word, read request for buffer address
      S_FCAP,    // capture buffer address
      S_READY,   // descriptor loaded, waiting for a frame start
      S_RECV,    // copying frame bytes
      S_DROP     // discarding a frame that arrived while held
   } eng_state_t;

   localparam logic [1:0] RA_BASE   = 2'd0;
   localparam logic [1:0] RA_LIMIT  = 2'd1;
   localparam logic [1:0] RA_STATUS = 2'd2;

   localparam int OVF_BIT    = 31;
   localparam int DESC_BYTES = 8;
   localparam int ADR_WORD   = 4;

endpackage

// File: rtl/rxring_csr.sv
module rxring_csr
   import rxring_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int POS_W      = 12,
   parameter int BASE_ALIGN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [POS_W-1:0]  pos_i,
   input  logic              ovf_set_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [POS_W-1:0]  lim_o
);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] base_mask;
   logic [POS_W-1:0]  lim_q;
   logic              ovf_q;
   logic              clr_hit;

   generate
      if (BASE_ALIGN > 0) begin : g_base_aligned
         assign base_mask = {{(ADDR_W-BASE_ALIGN){1'b1}}, {BASE_ALIGN{1'b0}}};
      end else begin : g_base_free
         assign base_mask = '1;
      end
   endgenerate

   assign clr_hit = reg_we && (reg_addr == RA_STATUS) && reg_wdata[OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         lim_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RA_BASE)
            base_q <= reg_wdata[ADDR_W-1:0] & base_mask;
         if (reg_we && reg_addr == RA_LIMIT)
            lim_q <= {reg_wdata[POS_W-1:3], 3'b000};
         if (ovf_set_i)
            ovf_q <= 1'b1;
         else if (clr_hit)
            ovf_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_BASE:   reg_rdata[ADDR_W-1:0] = base_q;
         RA_LIMIT:  reg_rdata[POS_W-1:0]  = lim_q;
         RA_STATUS: begin
            reg_rdata[POS_W-1:0] = pos_i;
            reg_rdata[OVF_BIT]   = ovf_q;
         end
         default:   reg_rdata = '0;
      endcase
   end

   assign base_o = base_q;
   assign lim_o  = lim_q;

   // R8: a drop always leaves the flag set, even against a clearing write
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set_i |=> ovf_q);

   // R8: a clearing write with no concurrent drop empties the flag
   a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !ovf_set_i) |=> !ovf_q);

   // R6: limit is always descriptor aligned
   a_r6_lim_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      lim_q[2:0] == 3'b000);

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
   import rxring_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int POS_W   = 12,
   parameter int LEN_W   = 13,
   parameter int EOT_BIT = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [POS_W-1:0]  lim_i,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic [POS_W-1:0]  pos_o,
   output logic              ovf_set_o,
   output logic              irq_o,
   output logic              err_o
);

   localparam logic [POS_W-1:0]  STEP    = POS_W'(DESC_BYTES);
   localparam logic [ADDR_W-1:0] ADR_OFS = ADDR_W'(ADR_WORD);

   eng_state_t        state_q;
   logic [POS_W-1:0]  pos_q;
   logic [LEN_W-1:0]  blen_q;
   logic              beot_q;
   logic [ADDR_W-1:0] baddr_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              trunc_q;
   logic              irq_q;
   logic              err_q;

   logic              stall;
   logic              take;
   logic              over;
   logic [ADDR_W-1:0] desc_addr;

   assign stall     = (pos_q == lim_i);
   assign take      = in_valid && ((state_q == S_RECV) || (state_q == S_READY && in_sof));
   assign over      = (cnt_q == blen_q);
   assign desc_addr = base_i + ADDR_W'(pos_q);

   assign in_ready  = (state_q == S_READY) || (state_q == S_RECV) ||
                      (state_q == S_DROP)  || (state_q == S_IDLE && stall);
   assign ovf_set_o = (state_q == S_IDLE) && stall && in_valid && in_sof;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = in_data;
      case (state_q)
         S_FCTL: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr;
         end
         S_FADR: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADR_OFS;
         end
         S_READY, S_RECV: begin
            if (take && !over) begin
               mem_req  = 1'b1;
               mem_we   = 1'b1;
               mem_addr = baddr_q + ADDR_W'(cnt_q);
            end
         end
         default: begin
            mem_req = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pos_q   <= '0;
         blen_q  <= '0;
         beot_q  <= 1'b0;
         baddr_q <= '0;
         cnt_q   <= '0;
         trunc_q <= 1'b0;
         irq_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         err_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (!stall)
                  state_q <= S_FCTL;
               else if (in_valid && in_sof && !in_eof)
                  state_q <= S_DROP;
            end
            S_FCTL: state_q <= S_FADR;
            S_FADR: begin
               blen_q  <= mem_rdata[LEN_W-1:0];
               beot_q  <= mem_rdata[EOT_BIT];
               state_q <= S_FCAP;
            end
            S_FCAP: begin
               baddr_q <= mem_rdata[ADDR_W-1:0];
               cnt_q   <= '0;
               trunc_q <= 1'b0;
               state_q <= S_READY;
            end
            S_READY, S_RECV: begin
               if (take) begin
                  if (in_eof) begin
                     irq_q   <= 1'b1;
                     err_q   <= trunc_q | over;
                     pos_q   <= beot_q ? '0 : pos_q + STEP;
                     state_q <= S_IDLE;
                  end else begin
                     state_q <= S_RECV;
                     if (over) trunc_q <= 1'b1;
                     else      cnt_q   <= cnt_q + 1'b1;
                  end
               end
            end
            S_DROP: begin
               if (in_valid && in_eof)
                  state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign pos_o = pos_q;
   assign irq_o = irq_q;
   assign err_o = err_q;

   // R4: completion pulse lasts one cycle
   a_r4_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R4, R5: position only ever steps one descriptor or returns to zero
   a_r4_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != $past(pos_q)) |-> ((pos_q == $past(pos_q) + STEP) || (pos_q == '0)));

   // R4: position moves only alongside a completion pulse
   a_r4_pos_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != $past(pos_q)) |-> irq_q);

   // R6: no memory traffic while held at the limit
   a_r6_quiet_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE || state_q == S_DROP) |-> !mem_req);

   // R7: a drop is only flagged while held at the limit
   a_r7_drop_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set_o |-> (pos_q == lim_i));

   // R9: no byte lands past the buffer length
   a_r9_write_in_len: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (cnt_q < blen_q));

   // R9: error flag only accompanies a completion
   a_r9_err_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> irq_q);

endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
   import rxring_pkg::*;
#(
   parameter int RING_DEPTH = 512,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 13,
   parameter int EOT_BIT    = 28,
   parameter int BASE_ALIGN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              irq_done,
   output logic              frame_err
);

   localparam int POS_W = $clog2(RING_DEPTH * DESC_BYTES);

   generate
      if (RING_DEPTH < 2 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("RING_DEPTH must be a power of two of at least 2");
      end
      if (ADDR_W > 32 || ADDR_W < POS_W) begin : g_bad_addr
         $error("ADDR_W must lie between the position width and 32");
      end
      if (POS_W > 31) begin : g_bad_pos
         $error("ring too large for the status field");
      end
      if (EOT_BIT < LEN_W || EOT_BIT > 31) begin : g_bad_eot
         $error("end-of-table bit must sit above the length field");
      end
      if (BASE_ALIGN < 0 || BASE_ALIGN > 3) begin : g_bad_align
         $error("BASE_ALIGN must be 0 to 3");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [POS_W-1:0]  lim;
   logic [POS_W-1:0]  pos;
   logic              ovf_set;

   rxring_csr #(
      .ADDR_W    (ADDR_W),
      .POS_W     (POS_W),
      .BASE_ALIGN(BASE_ALIGN)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .pos_i    (pos),
      .ovf_set_i(ovf_set),
      .base_o   (base),
      .lim_o    (lim)
   );

   rxring_engine #(
      .ADDR_W (ADDR_W),
      .POS_W  (POS_W),
      .LEN_W  (LEN_W),
      .EOT_BIT(EOT_BIT)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_i   (base),
      .lim_i    (lim),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .pos_o    (pos),
      .ovf_set_o(ovf_set),
      .irq_o    (irq_done),
      .err_o    (frame_err)
   );

endmodule

// File: tb/sim_rxring_dma.sv
`timescale 1ns/1ps
module sim_rxring_dma;

   localparam int BASE = 32'h200;
   localparam int BUF0 = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd2;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_sof = 1'b0;
   logic        in_eof = 1'b0;
   logic        irq_done, frame_err;

   always #5 clk = ~clk;

   rxring_dma u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof),
      .irq_done(irq_done), .frame_err(frame_err)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   logic [7:0] mem [0:8191];
   int  dlen [0:3] = '{16, 4, 8, 8};
   bit  deot [0:3] = '{0, 0, 0, 1};

   logic [39:0] wq [$];   // {addr, byte}
   logic [12:0] cq [$];   // {err, pos}
   int exp_pos = 0;
   int exp_lim = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: byte writes, word reads with one cycle latency
   always @(posedge clk) begin
      if (mem_req && mem_we)
         mem[mem_addr[12:0]] <= mem_wdata;
      if (mem_req && !mem_we)
         mem_rdata <= {mem[mem_addr[12:0]+13'd3], mem[mem_addr[12:0]+13'd2],
                       mem[mem_addr[12:0]+13'd1], mem[mem_addr[12:0]]};
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_we) begin
            if (wq.size() == 0)
               chk(0, "R3/R7 unexpected write", mem_addr, 32'hffffffff);
            else begin
               logic [39:0] e;
               e = wq.pop_front();
               chk({mem_addr, mem_wdata} == e, "R3 buffer write", {mem_addr[23:0], mem_wdata}, e[31:0]);
            end
         end
         if (mem_req && !mem_we)
            chk(mem_addr == BASE + exp_pos || mem_addr == BASE + exp_pos + 4,
                "R2 descriptor read", mem_addr, BASE + exp_pos);
         if (irq_done) begin
            if (cq.size() == 0)
               chk(0, "R4/R7 unexpected irq", reg_rdata, 32'hffffffff);
            else begin
               logic [12:0] c;
               c = cq.pop_front();
               chk(reg_rdata[11:0] == c[11:0], "R4 status position at irq", reg_rdata[11:0], c[11:0]);
               chk(frame_err == c[12], "R9 error flag", frame_err, c[12]);
            end
         end
      end
   end

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0; reg_addr = 2'd2;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
      @(posedge clk); #3;
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = 2'd2;
   endtask

   task automatic put_byte(input logic [7:0] d, input logic s, input logic e);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   // driver: predict writes and completion, then send
   task automatic send_frame(input int n, input logic [7:0] seed);
      bit drop;
      int k, np;
      drop = (exp_pos == exp_lim);
      k = exp_pos / 8;
      np = deot[k] ? 0 : exp_pos + 8;
      if (!drop) begin
         for (int i = 0; i < n; i++)
            if (i < dlen[k]) wq.push_back({32'(BUF0 + k*256 + i), 8'(seed + i)});
         cq.push_back({(n > dlen[k]) ? 1'b1 : 1'b0, 12'(np)});
      end
      for (int i = 0; i < n; i++)
         put_byte(8'(seed + i), i == 0, i == n - 1);
      if (!drop) exp_pos = np;
      repeat (6) @(posedge clk);
   endtask

   initial begin
      #2000000;
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
      for (int k = 0; k < 4; k++) begin
         logic [31:0] ctl, ba;
         ctl = 32'(dlen[k]) | (deot[k] ? 32'h1000_0000 : 32'h0);
         ba  = BUF0 + k*256;
         for (int b = 0; b < 4; b++) begin
            mem[BASE + k*8 + b]     = ctl[8*b +: 8];
            mem[BASE + k*8 + 4 + b] = ba[8*b +: 8];
         end
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R10: reset values
      reg_rd(2'd0, r); chk(r == 0, "R1 base reset", r, 0);
      reg_rd(2'd1, r); chk(r == 0, "R1 limit reset", r, 0);
      reg_rd(2'd2, r); chk(r == 0, "R1 status reset", r, 0);
      chk(!irq_done && !frame_err && !mem_req, "R1 outputs idle", {irq_done, frame_err, mem_req}, 0);

      // R10: base alignment
      reg_wr(2'd0, BASE + 5);
      reg_rd(2'd0, r); chk(r == BASE, "R10 base readback", r, BASE);

      // R6: open three descriptors
      exp_lim = 32'h18;
      reg_wr(2'd1, 32'h18);
      repeat (6) @(posedge clk);
      send_frame(10, 8'h10);   // R3 within length
      send_frame(6, 8'h40);    // R9 truncated
      send_frame(8, 8'h80);    // R9 exact fill
      reg_rd(2'd2, r); chk(r == 32'h18, "R6 held at limit", r, 32'h18);

      // R7: frame while held is dropped
      send_frame(5, 8'hc0);
      reg_rd(2'd2, r); chk(r == 32'h8000_0018, "R7 overflow set, position kept", r, 32'h8000_0018);

      // R8: writing 0 keeps, writing 1 clears
      reg_wr(2'd2, 32'h0);
      reg_rd(2'd2, r); chk(r[31] == 1'b1, "R8 write zero keeps flag", r[31], 1);
      reg_wr(2'd2, 32'h8000_0000);
      reg_rd(2'd2, r); chk(r[31] == 1'b0, "R8 write one clears flag", r[31], 0);

      // R8: same cycle drop and clear -> set wins
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h8000_0000;
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h55;
      @(posedge clk); #1;
      reg_we = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      reg_rd(2'd2, r); chk(r[31] == 1'b1, "R8 set beats clear", r[31], 1);
      reg_wr(2'd2, 32'h8000_0000);

      // R6: low limit bits ignored
      exp_lim = 32'h10;
      reg_wr(2'd1, 32'h13);
      reg_rd(2'd1, r); chk(r == 32'h10, "R6 limit readback", r, 32'h10);
      repeat (6) @(posedge clk);

      // R5: end-of-table descriptor wraps
      send_frame(3, 8'h20);
      reg_rd(2'd2, r); chk(r == 32'h0, "R5 wrap to zero", r, 0);

      // R11: stray byte without frame start
      put_byte(8'hee, 1'b0, 1'b0);
      put_byte(8'hef, 1'b0, 1'b1);
      repeat (4) @(posedge clk);
      chk(wq.size() == 0 && cq.size() == 0, "R11 stray bytes ignored", wq.size(), 0);

      send_frame(1, 8'h30);    // single-byte frame on descriptor 0
      send_frame(5, 8'h60);    // R9 truncated on descriptor 1
      reg_rd(2'd2, r); chk(r == 32'h10, "R6 held at new limit", r, 32'h10);

      chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
      chk(cq.size() == 0, "R4 all completions seen", cq.size(), 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule